// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder and Demultiplexer

The block turns a binary select address into a one-of-sixteen selection on its output lines. A storage stage in front of the decoder holds the address. While the latch enable is high the stage is transparent, and the outputs follow the select inputs in the same cycle. While it is low the stage keeps its held value, and changes on the select inputs have no effect. The stage is built in a clocked style: it loads on each rising clock edge where the latch enable is high, and a bypass path carries the live address through while the latch enable is high.

An active-low enable input gates the decoded result combinationally at all times, whether or not the address is held. Two uses follow from this. Driving serial data onto the enable input routes that data to the addressed line, so the block works as a 1-to-16 demultiplexer. Driving the enable from upper address bits lets several blocks be cascaded into a wider decoder, with the enable acting as a chip select. A parameter sets the output polarity. In the active-high variant the selected line is driven high. In the active-low variant it is driven low. The idle level of all lines follows the chosen polarity.

Top module: `latched_decoder`

## Requirements
- R1: While `latch_en_i` is 1, the outputs decode the present `addr_i` in the same cycle, with no clock delay.
- R2: While `latch_en_i` is 0, `addr_i` has no effect. The decoded address is the `addr_i` value sampled at the last rising clock edge at which `latch_en_i` was 1.
- R3: The address is unsigned binary, with `addr_i[3]` as the most significant bit. Address value n selects `lines_o[n]`.
- R4: With `en_ni` = 0, exactly one line is at the active level, namely the addressed one. With `en_ni` = 1, every line is at the idle level whatever the address and the latch enable. The enable acts combinationally.
- R5: When POL = OUT_ACT_HIGH, the active level is 1 and the idle level is 0.
- R6: When POL = OUT_ACT_LOW, the active level is 0 and the idle level is 1, so the outputs are the bitwise complement of the active-high outputs.
- R7: When data is driven on `en_ni` with the address held, the addressed line carries that data, inverted in the active-high variant and unchanged in the active-low variant. All other lines stay idle.
- R8: Two blocks can form a 32-line decoder. A fifth address bit is ORed into one block's enable and, inverted, into the other's. The result is one-hot over 32 lines, with the fifth bit selecting the upper block.
- R9: `rst_ni` = 0 clears the held address to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the address storage |
| rst_ni | input | 1 | Asynchronous active-low reset of the held address |
| latch_en_i | input | 1 | 1: address transparent; 0: address held |
| addr_i | input | 4 | Binary select address |
| en_ni | input | 1 | Active-low enable, demux data or chip select |
| lines_o | output | 16 | Decoded output lines |

## Verification
On every cycle, the assertions check four things: the held address stays stable while the latch enable stays low, the addressed line is active whenever the enable is low, the outputs track the live address while the stage is transparent, and every line sits idle while the enable is high. Some behaviours only the bench scenarios can show. These are the full sweep of all sixteen addresses in both polarities, the hold value taken at a latch-enable falling edge while the address changes at that same moment, serial data on the enable input, an asynchronous reset in mid-run, and the 32-line one-hot result of a cascaded pair.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  typedef enum logic {
    OUT_ACT_LOW  = 1'b0,
    OUT_ACT_HIGH = 1'b1
  } out_pol_e;
endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (le_i) addr_q <= addr_i;
  end

  // transparent path bypasses storage
  assign addr_o = le_i ? addr_i : addr_q;

  // R2: held address stable across consecutive low-enable cycles
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !$past(le_i)) |-> $stable(addr_o));
endmodule

// File: rtl/bin_decoder.sv
module bin_decoder #(
  parameter int unsigned W = 4,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] addr_i,
  output logic [N-1:0] hit_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_hit
    assign hit_o[gi] = (addr_i == W'(gi));
  end
endmodule

// File: rtl/line_driver.sv
module line_driver #(
  parameter int unsigned N = 16,
  parameter latdec_pkg::out_pol_e POL = latdec_pkg::OUT_ACT_HIGH
) (
  input  logic [N-1:0] hit_i,
  input  logic         en_ni,
  output logic [N-1:0] lines_o
);
  logic [N-1:0] gated;
  assign gated = en_ni ? '0 : hit_i;

  if (POL == latdec_pkg::OUT_ACT_HIGH) begin : g_high
    assign lines_o = gated;
  end else begin : g_low
    assign lines_o = ~gated;
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned ADDR_W = 4,
  parameter latdec_pkg::out_pol_e POL = latdec_pkg::OUT_ACT_HIGH,
  localparam int unsigned N_LINES = 1 << ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               en_ni,
  output logic [N_LINES-1:0] lines_o
);
  localparam logic ACT_LVL = (POL == latdec_pkg::OUT_ACT_HIGH);
  localparam logic [N_LINES-1:0] IDLE_VEC = {N_LINES{~ACT_LVL}};

  logic [ADDR_W-1:0]  addr_eff;
  logic [N_LINES-1:0] hit;

  addr_latch #(.W(ADDR_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (latch_en_i),
    .addr_i (addr_i),
    .addr_o (addr_eff)
  );

  bin_decoder #(.W(ADDR_W)) u_dec (
    .addr_i (addr_eff),
    .hit_o  (hit)
  );

  line_driver #(.N(N_LINES), .POL(POL)) u_drv (
    .hit_i   (hit),
    .en_ni   (en_ni),
    .lines_o (lines_o)
  );

  // R4: disabled means every line idle
  a_r4_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (lines_o == IDLE_VEC));
  // R4: enabled means exactly one active line
  a_r4_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> ($countones(lines_o ^ IDLE_VEC) == 1));
  // R3: active line index equals decoded address
  a_r3_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> (lines_o[addr_eff] == ACT_LVL));
  // R1: transparent stage follows live address
  a_r1_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && !en_ni) |-> (lines_o[addr_i] == ACT_LVL));
endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       le = 1'b0;
  logic       en = 1'b0;
  logic [4:0] a5 = 5'd9;
  logic       run = 1'b0;
  string      tag = "R9";

  int compared = 0;
  int mismatched = 0;

  logic [15:0] y_hi, y_lo, y_c0, y_c1;

  always #4ns clk = ~clk;

  latched_decoder #(.POL(latdec_pkg::OUT_ACT_HIGH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(le), .addr_i(a5[3:0]),
    .en_ni(en), .lines_o(y_hi));
  latched_decoder #(.POL(latdec_pkg::OUT_ACT_LOW)) u_dut_lo (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(le), .addr_i(a5[3:0]),
    .en_ni(en), .lines_o(y_lo));
  latched_decoder #(.POL(latdec_pkg::OUT_ACT_HIGH)) u_casc0 (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(le), .addr_i(a5[3:0]),
    .en_ni(en | a5[4]), .lines_o(y_c0));
  latched_decoder #(.POL(latdec_pkg::OUT_ACT_HIGH)) u_casc1 (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(le), .addr_i(a5[3:0]),
    .en_ni(en | ~a5[4]), .lines_o(y_c1));

  // behavioural reference: held address
  int held = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 0;
    else if (le) held <= int'(a5[3:0]);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s/%s: actual %h expected %h (t=%0t)", tag, req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      int eff;
      logic [31:0] e16, e32;
      eff = le ? int'(a5[3:0]) : held;
      e16 = en ? 32'h0 : (32'h1 << eff);
      e32 = en ? 32'h0 : (32'h1 << (eff + (a5[4] ? 16 : 0)));
      check("R5", {16'h0, y_hi}, e16);
      check("R6", {16'h0, y_lo}, {16'h0, ~e16[15:0]});
      check("R8", {y_c1, y_c0}, e32);
    end
  end

  task automatic step(input logic l, input logic e, input logic [4:0] a, input string t);
    @(posedge clk);
    #2ns;
    le = l; en = e; a5 = a; tag = t;
  endtask

  initial begin
    #1ns rst_n = 1'b0;
    run = 1'b1;
    // R9: reset clears held address to 0
    step(1'b0, 1'b0, 5'd9, "R9");
    step(1'b0, 1'b0, 5'd13, "R9");
    @(posedge clk); #2ns rst_n = 1'b1;
    // R1/R3: transparent sweep of all addresses, both halves of cascade
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 5'(i), "R1_R3");
    for (int i = 31; i >= 0; i -= 3) step(1'b1, 1'b0, 5'(i), "R3");
    // R2: capture 5, drop latch enable while address changes
    step(1'b1, 1'b0, 5'd5, "R2");
    step(1'b0, 1'b0, 5'd12, "R2");
    step(1'b0, 1'b0, 5'd15, "R2");
    step(1'b0, 1'b0, 5'd0, "R2");
    step(1'b0, 1'b0, 5'd21, "R2");
    step(1'b1, 1'b0, 5'd14, "R2");
    step(1'b0, 1'b0, 5'd3, "R2");
    // R4: enable high idles all lines, either latch mode
    step(1'b0, 1'b1, 5'd7, "R4");
    step(1'b1, 1'b1, 5'd10, "R4");
    step(1'b1, 1'b1, 5'd26, "R4");
    step(1'b1, 1'b0, 5'd10, "R4");
    // R7: serial data on enable with held address 10
    step(1'b0, 1'b1, 5'd1, "R7");
    step(1'b0, 1'b0, 5'd2, "R7");
    step(1'b0, 1'b0, 5'd17, "R7");
    step(1'b0, 1'b1, 5'd17, "R7");
    step(1'b0, 1'b0, 5'd4, "R7");
    step(1'b0, 1'b1, 5'd4, "R7");
    // R9: asynchronous reset mid-run with latch closed
    step(1'b1, 1'b0, 5'd11, "R9");
    step(1'b0, 1'b0, 5'd6, "R9");
    rst_n = 1'b0;
    step(1'b0, 1'b0, 5'd8, "R9");
    @(posedge clk); #2ns rst_n = 1'b1;
    step(1'b0, 1'b0, 5'd25, "R9");
    step(1'b0, 1'b0, 5'd2, "R9");
    @(posedge clk);
    @(negedge clk);
    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800us;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule